// File: doc/BRIEF.md
# Fan Tachometer Period Checker

This block times the pulse train coming back from a cooling fan. The raw tachometer line is brought into the system clock domain. The block then counts system clock cycles between consecutive rising edges and publishes each count as the latest period. Every published period is compared against a programmed expected period with a symmetric tolerance. A count outside that window is flagged as a tachometer fault. Software converts the period to revolutions per minute. Pulses per revolution may be 1, 2 or 4, and the conversion is rpm = 60 · f_clk / (pulses · period).

The block also owns the event and interrupt logic of the fan controller. There are four event sources. Two of them come from this block: a new measurement and a tachometer fault. The other two are strobes from the PWM side: a duty change and a temperature-driven duty request. Events latch into a pending register, which software clears by writing ones. A mask register decides which pending bits drive the level interrupt.

In normal use, software clears the mask and waits for a software-initiated duty change. It then takes a fresh measurement and reprograms the expected period to that value, with a tolerance of about a quarter of it. If the fan stalls, the period counter saturates. The block then reports a zero period together with a fault.

Top module: `fan_tach_monitor`

## Requirements
- R1: The period register (offset 0x0C4, bits CNT_W-1:0) holds the number of clock cycles between the two most recent detected rising edges of the tachometer. The first edge after reset, or after a stall, only starts a count and publishes nothing.
- R2: The tachometer input passes two synchroniser flops and an edge detector. When the input rises before clock edge k, the period register and pending bits change at edge k+2.
- R3: A published period outside the inclusive window [expected − tolerance, expected + tolerance] sets pending bit 1. The lower bound is clamped at zero. The expected period is read and written at offset 0x088 and the tolerance at offset 0x08C, each CNT_W bits wide.
- R4: Every published period, including a stall result, sets pending bit 3.
- R5: If the counter reaches 2^CNT_W − 1 with no edge, the block publishes a period of 0 and sets pending bits 1 and 3. The next edge only restarts the count.
- R6: The pending register at offset 0x044 is cleared by writing 1 to a bit. When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: The mask register at offset 0x040 (bits 3:0) resets to 4'hF, and a 1 masks its source. The source register at offset 0x048 reads pending AND NOT mask.
- R8: irq_o is high exactly while at least one pending bit is set whose mask bit is 0.
- R9: A pulse on pwm_changed_i sets pending bit 0, and a pulse on temp_req_i sets pending bit 2.
- R10: After reset, the period, pending, expected and tolerance registers read 0 and irq_o is low. Any offset that is not mapped reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Raw tachometer line from the fan |
| pwm_changed_i | input | 1 | One-cycle strobe: duty cycle has changed |
| temp_req_i | input | 1 | One-cycle strobe: temperature logic requested a new duty |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
The measurement path and the software clear path can hit the same pending bit in one cycle: a new-measurement event at edge k+2 and a write-one-to-clear of bit 3 landing on that same edge. The bench provokes this by raising the tachometer line, waiting the two synchroniser cycles, and issuing the clear exactly on the third edge. It then judges that bit 3 reads back set. A reference model that updates on every clock applies the same set-over-clear rule. It also tracks stall timing and window boundaries, and it compares the addressed register and the interrupt on every cycle.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  localparam int unsigned NUM_EV  = 4;
  localparam int unsigned EV_PWM  = 0;
  localparam int unsigned EV_TERR = 1;
  localparam int unsigned EV_TEMP = 2;
  localparam int unsigned EV_MEAS = 3;

  localparam logic [11:0] OFS_MASK = 12'h040;
  localparam logic [11:0] OFS_PEND = 12'h044;
  localparam logic [11:0] OFS_SRC  = 12'h048;
  localparam logic [11:0] OFS_EXP  = 12'h088;
  localparam logic [11:0] OFS_TOL  = 12'h08C;
  localparam logic [11:0] OFS_MEAS = 12'h0C4;

  // Inclusive window test; lower bound clamps at zero.
  function automatic logic in_window(input logic [31:0] meas,
                                     input logic [31:0] expv,
                                     input logic [31:0] tol);
    logic [32:0] lo;
    logic [32:0] hi;
    hi = {1'b0, expv} + {1'b0, tol};
    lo = (expv >= tol) ? {1'b0, expv - tol} : 33'd0;
    return ({1'b0, meas} >= lo) && ({1'b0, meas} <= hi);
  endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_raw_i,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= tach_raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter
  import fan_tach_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] exp_i,
  input  logic [CNT_W-1:0] tol_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             publish_o,
  output logic             err_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             edge_pub;
  logic             outside;

  always_comb begin
    edge_pub  = rise_i && armed_q;
    timeout_o = !rise_i && (cnt_q == CNT_MAX);
    outside   = !in_window(32'(cnt_q), 32'(exp_i), 32'(tol_i));
    publish_o = edge_pub || timeout_o;
    err_o     = timeout_o || (edge_pub && outside);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      meas_o  <= '0;
    end else if (rise_i) begin
      if (armed_q) meas_o <= cnt_q;
      armed_q <= 1'b1;
      cnt_q   <= CNT_ONE;
    end else if (timeout_o) begin
      meas_o  <= '0;
      armed_q <= 1'b0;
      cnt_q   <= CNT_ONE;
    end else begin
      cnt_q   <= cnt_q + CNT_ONE;
    end
  end

endmodule

// File: rtl/fan_irq_ctrl.sv
module fan_irq_ctrl #(
  parameter int unsigned NEV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_i,
  input  logic [NEV-1:0] clr_i,
  input  logic           mask_wr_i,
  input  logic [NEV-1:0] mask_wdata_i,
  output logic [NEV-1:0] mask_o,
  output logic [NEV-1:0] pend_o,
  output logic [NEV-1:0] src_o,
  output logic           irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_o <= '1;
    else if (mask_wr_i) mask_o <= mask_wdata_i;
  end

  generate
    genvar b;
    for (b = 0; b < NEV; b++) begin : g_pend
      always_ff @(posedge clk) begin
        if (!rst_n)       pend_o[b] <= 1'b0;
        else if (ev_i[b]) pend_o[b] <= 1'b1;
        else if (clr_i[b]) pend_o[b] <= 1'b0;
      end
    end
  endgenerate

  assign src_o = pend_o & ~mask_o;
  assign irq_o = |src_o;

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_in,
  input  logic              pwm_changed_i,
  input  logic              temp_req_i,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);
  localparam logic [ADDR_W-1:0] A_EXP  = ADDR_W'(OFS_EXP);
  localparam logic [ADDR_W-1:0] A_TOL  = ADDR_W'(OFS_TOL);
  localparam logic [ADDR_W-1:0] A_MEAS = ADDR_W'(OFS_MEAS);

  // Named internal events, visible to the bound checker.
  logic              rise_evt;
  logic              publish_evt;
  logic              err_evt;
  logic              timeout_evt;
  logic [CNT_W-1:0]  meas_q;
  logic [CNT_W-1:0]  exp_q;
  logic [CNT_W-1:0]  tol_q;
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] clr_vec;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] pend_q;
  logic [NUM_EV-1:0] src_w;
  logic              mask_wr;

  tach_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tach_raw_i (tach_in),
    .rise_o     (rise_evt)
  );

  tach_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise_evt),
    .exp_i     (exp_q),
    .tol_i     (tol_q),
    .meas_o    (meas_q),
    .publish_o (publish_evt),
    .err_o     (err_evt),
    .timeout_o (timeout_evt)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_PWM]  = pwm_changed_i;
    ev_vec[EV_TERR] = err_evt;
    ev_vec[EV_TEMP] = temp_req_i;
    ev_vec[EV_MEAS] = publish_evt;
    clr_vec = (reg_wr_en && reg_addr == A_PEND) ? reg_wdata[NUM_EV-1:0] : '0;
    mask_wr = reg_wr_en && (reg_addr == A_MASK);
  end

  fan_irq_ctrl #(.NEV(NUM_EV)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_i         (ev_vec),
    .clr_i        (clr_vec),
    .mask_wr_i    (mask_wr),
    .mask_wdata_i (reg_wdata[NUM_EV-1:0]),
    .mask_o       (mask_q),
    .pend_o       (pend_q),
    .src_o        (src_w),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      tol_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == A_EXP) exp_q <= reg_wdata[CNT_W-1:0];
      if (reg_addr == A_TOL) tol_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = 32'(mask_q);
      A_PEND:  reg_rdata = 32'(pend_q);
      A_SRC:   reg_rdata = 32'(src_w);
      A_EXP:   reg_rdata = 32'(exp_q);
      A_TOL:   reg_rdata = 32'(tol_q);
      A_MEAS:  reg_rdata = 32'(meas_q);
      default: reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned NEV   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             publish,
  input logic             err,
  input logic             timeout,
  input logic [CNT_W-1:0] meas,
  input logic [NEV-1:0]   ev,
  input logic [NEV-1:0]   clr,
  input logic [NEV-1:0]   pend,
  input logic [NEV-1:0]   mask,
  input logic             irq
);

  a_r4_meas_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> pend[3]);

  a_r3_err_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> pend[1]);

  a_r5_stall_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (meas == '0));

  a_r1_meas_moves_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas) |-> $past(publish));

  a_r9_pwm_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> pend[0]);

  a_r9_temp_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev[2] |=> pend[2]);

  a_r7_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == {NEV{1'b1}}) |-> !irq);

  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

  generate
    genvar g;
    for (g = 0; g < NEV; g++) begin : g_w1c
      // R6: a pending bit drops only after a clear that met no event
      a_r6_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[g]) |-> ($past(clr[g]) && !$past(ev[g])));
    end
  endgenerate

endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.CNT_W(CNT_W), .NEV(fan_tach_pkg::NUM_EV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .publish (publish_evt),
  .err     (err_evt),
  .timeout (timeout_evt),
  .meas    (meas_q),
  .ev      (ev_vec),
  .clr     (clr_vec),
  .pend    (pend_q),
  .mask    (mask_q),
  .irq     (irq_o)
);

// File: tb/sim_fan_tach_monitor.sv
`timescale 1ns/1ps
module sim_fan_tach_monitor;
  localparam int CW   = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach_in = 1'b0;
  logic        pwm_changed_i = 1'b0;
  logic        temp_req_i = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = 12'h040;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  always #2.5 clk = ~clk;

  fan_tach_monitor #(.CNT_W(CW), .ADDR_W(12), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in),
    .pwm_changed_i(pwm_changed_i), .temp_req_i(temp_req_i),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // ---------------- behavioural reference model ----------------
  bit syncq[$];
  int m_cnt, m_meas, m_pend, m_mask, m_exp, m_tol, m_evv, m_clr, m_lo;
  bit m_armed, m_rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      syncq = '{0, 0, 0};
      m_cnt = 0; m_meas = 0; m_pend = 0; m_mask = 15; m_exp = 0; m_tol = 0;
      m_armed = 0;
    end else begin
      m_rise = syncq[1] && !syncq[2];
      m_evv  = 0;
      if (m_rise) begin
        if (m_armed) begin
          m_meas = m_cnt;
          m_evv  = m_evv | 8;
          m_lo   = m_exp - m_tol;
          if (m_lo < 0) m_lo = 0;
          if (m_cnt < m_lo || m_cnt > m_exp + m_tol) m_evv = m_evv | 2;
        end
        m_armed = 1; m_cnt = 1;
      end else if (m_cnt == CMAX) begin
        m_meas = 0; m_evv = m_evv | 10; m_armed = 0; m_cnt = 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (pwm_changed_i) m_evv = m_evv | 1;
      if (temp_req_i)    m_evv = m_evv | 4;
      m_clr  = (reg_wr_en && reg_addr == 12'h044) ? int'(reg_wdata & 32'hF) : 0;
      m_pend = (m_pend & ~m_clr) | m_evv;
      if (reg_wr_en && reg_addr == 12'h040) m_mask = int'(reg_wdata & 32'hF);
      if (reg_wr_en && reg_addr == 12'h088) m_exp  = int'(reg_wdata & CMAX);
      if (reg_wr_en && reg_addr == 12'h08C) m_tol  = int'(reg_wdata & CMAX);
      syncq.push_front(tach_in);
      void'(syncq.pop_back());
    end
  end

  function automatic int model_read(input logic [11:0] a);
    case (a)
      12'h040: return m_mask;
      12'h044: return m_pend;
      12'h048: return m_pend & ~m_mask & 15;
      12'h088: return m_exp;
      12'h08C: return m_tol;
      12'h0C4: return m_meas;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h040, 12'h048: return "R7";
      12'h044: return "R6";
      12'h088, 12'h08C: return "R3";
      12'h0C4: return "R1";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string r, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, expv, $time);
    end
  endtask

  // One clock: model and DUT update on the edge; compare at the falling edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk(req_of(reg_addr), int'(reg_rdata), model_read(reg_addr));
    chk("R8", int'(irq_o), ((m_pend & ~m_mask & 15) != 0) ? 1 : 0);
  endtask

  task automatic wr(input logic [11:0] a, input int d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = 32'(d);
    cycle();
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output int v);
    reg_addr = a;
    cycle();
    v = int'(reg_rdata);
  endtask

  logic [11:0] rot[6] = '{12'h040, 12'h044, 12'h048, 12'h088, 12'h08C, 12'h0C4};
  int rix = 0;

  task automatic idle_rot();
    reg_addr = rot[rix];
    rix = (rix + 1) % 6;
    cycle();
  endtask

  // n pulses of period p; optional clear of all pending bits as pulse 1 starts
  task automatic run_tach(input int p, input int n, input bit clr1);
    for (int k = 0; k < n; k++) begin
      tach_in = 1;
      for (int c = 0; c < p / 2; c++) begin
        if (clr1 && k == 1 && c == 0) wr(12'h044, 15);
        else idle_rot();
      end
      tach_in = 0;
      for (int c = 0; c < p - p / 2; c++) idle_rot();
    end
  endtask

  task automatic window_case(input int p, input int want_err);
    int v;
    run_tach(p, 3, 1);
    rd(12'h0C4, v); chk("R1", v, p);
    rd(12'h044, v); chk("R3", (v >> 1) & 1, want_err);
  endtask

  initial begin
    int v;
    repeat (4) cycle();
    rst_n = 1;
    // R10 reset state
    rd(12'h0C4, v); chk("R10", v, 0);
    rd(12'h044, v); chk("R10", v, 0);
    rd(12'h088, v); chk("R10", v, 0);
    rd(12'h08C, v); chk("R10", v, 0);
    rd(12'h100, v); chk("R10", v, 0);
    chk("R10", int'(irq_o), 0);
    rd(12'h040, v); chk("R7", v, 15);

    wr(12'h088, 100);
    wr(12'h08C, 25);
    rd(12'h088, v); chk("R3", v, 100);
    run_tach(100, 4, 0);
    rd(12'h0C4, v); chk("R1", v, 100);
    rd(12'h044, v); chk("R4", (v >> 3) & 1, 1);
    chk("R7", int'(irq_o), 0);
    wr(12'h040, 0);
    chk("R8", int'(irq_o), 1);
    wr(12'h044, 15);
    rd(12'h044, v); chk("R6", v, 0);
    chk("R8", int'(irq_o), 0);

    // R3 window edges, inclusive both sides
    window_case(100, 0);
    window_case(125, 0);
    window_case(75, 0);
    window_case(126, 1);
    window_case(74, 1);

    // R9 strobes, R7 source view
    wr(12'h044, 15);
    pwm_changed_i = 1; cycle(); pwm_changed_i = 0;
    rd(12'h044, v); chk("R9", v & 1, 1);
    temp_req_i = 1; cycle(); temp_req_i = 0;
    rd(12'h044, v); chk("R9", (v >> 2) & 1, 1);
    wr(12'h040, 1);
    rd(12'h048, v); chk("R7", v, 4);
    wr(12'h040, 5);
    chk("R8", int'(irq_o), 0);
    wr(12'h040, 0);

    // R2 latency: pending bit 3 appears on the third edge after the rise
    wr(12'h044, 15);
    reg_addr = 12'h044;
    tach_in = 1;
    cycle(); cycle();
    chk("R2", int'(reg_rdata[3]), 0);
    cycle();
    chk("R2", int'(reg_rdata[3]), 1);
    tach_in = 0;
    repeat (60) idle_rot();

    // R6 coincidence: clear of bit 3 on the same edge as the measurement event
    wr(12'h044, 15);
    tach_in = 1;
    cycle(); cycle();
    wr(12'h044, 8);
    rd(12'h044, v); chk("R6", (v >> 3) & 1, 1);
    tach_in = 0;
    repeat (20) idle_rot();

    // R5 stall
    wr(12'h044, 15);
    repeat (1100) idle_rot();
    rd(12'h0C4, v); chk("R5", v, 0);
    rd(12'h044, v); chk("R5", v & 10, 10);
    wr(12'h044, 15);
    run_tach(100, 1, 0);
    rd(12'h0C4, v); chk("R5", v, 0);
    rd(12'h044, v); chk("R5", (v >> 3) & 1, 0);
    run_tach(100, 2, 0);
    rd(12'h0C4, v); chk("R1", v, 100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule